// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-controlled master for the two-wire PHY management bus (Clause 22 frames). Software first sets a clock divisor and an enable bit in a setup register. For a write it then stages the 16-bit payload in a data register. Finally it writes one packed command word that carries the PHY address, the register address, the operation and a launch bit. The block sends the frame on the management clock and data pins, and a ready flag in the command word returns high when the frame is over. For a read, the captured 16-bit value is then available in a result register.

The management clock runs only while a frame is in flight and rests low otherwise. The master changes its data output on falling clock edges. It samples read data on rising edges, and it releases the data line for the turnaround and the read payload.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset the setup register (offset 0x00) reads divisor 29 in bits 5:0 with the enable (bit 6) clear, the command register (offset 0x04) reads 0x00000080, and the clock and data-enable pins are low.
- R2: While a frame runs, the management clock period is 2*(divisor+1) system clocks. The clock stays low whenever no frame is running.
- R3: While the enable bit is clear, a launch request starts no frame, produces no clock edge and leaves ready high.
- R4: A command write launches a frame only when bit 11 is set and exactly one of bit 15 (read) or bit 14 (write) is set. The PHY address sits in bits 28:24 and the register address in bits 20:16, and these fields and the operation bits read back.
- R5: Bit 7 of the command register reads low from just after an accepted launch until the frame ends, then high. Bit 11 always reads zero.
- R6: Each frame is 64 bits sent MSB first: 32 ones, then 01, then opcode 10 (read) or 01 (write), then the 5-bit PHY address, then the 5-bit register address. The data output changes only on falling clock edges.
- R7: A write frame drives turnaround 10 and then bits 15:0 of the write-data register (offset 0x08), with the output enable high for all 64 bits.
- R8: A read frame releases the output enable for its last 18 bits. It samples 16 bits MSB first on rising clock edges, and the value appears in bits 15:0 of the result register (offset 0x0C) once ready is high.
- R9: A command write made while a frame runs is ignored entirely: no second frame is sent and the command fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for bus_addr, one cycle behind |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or shift state shows at the pins within the frame it corrupts. A field lands in the wrong slot, the enable drops at the wrong bit, or the clock keeps running after bit 63, and a PHY model catches each of these when it decodes that frame. A wrong busy state shows on the next read of the command register as a ready flag in the wrong state, or as a second frame the scoreboard did not expect. A corrupted sampling state shows as a wrong read result as soon as ready returns.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int OFS_CFG  = 'h0;
  localparam int OFS_CTRL = 'h4;
  localparam int OFS_WDAT = 'h8;
  localparam int OFS_RDAT = 'hC;

  localparam int CFG_EN_BIT  = 6;
  localparam int CTL_PHY_LSB = 24;
  localparam int CTL_REG_LSB = 16;
  localparam int CTL_RD_BIT  = 15;
  localparam int CTL_WR_BIT  = 14;
  localparam int CTL_GO_BIT  = 11;
  localparam int CTL_RDY_BIT = 7;
  localparam int ADR_W       = 5;

  typedef struct packed {
    logic             is_rd;
    logic [ADR_W-1:0] phy;
    logic [ADR_W-1:0] regad;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 29,
  parameter int DAT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy_i,
  input  logic [DAT_W-1:0]  result_i,
  output logic              start_o,
  output mdio_cmd_t         cmd_o,
  output logic [DAT_W-1:0]  wdat_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              en_o
);
  logic [DIV_W-1:0]  div_q;
  logic              en_q;
  mdio_cmd_t         cmd_q;
  logic              wr_sel_q;
  logic [DAT_W-1:0]  wdat_q;
  logic [DATA_W-1:0] mux;

  logic ctrl_hit, op_rd, op_wr;
  assign ctrl_hit = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign op_rd    = wdata[CTL_RD_BIT];
  assign op_wr    = wdata[CTL_WR_BIT];
  assign start_o  = ctrl_hit && !busy_i && en_q && wdata[CTL_GO_BIT] && (op_rd ^ op_wr);

  always_comb begin
    mux = '0;
    case (addr)
      ADDR_W'(OFS_CFG): begin
        mux[DIV_W-1:0]  = div_q;
        mux[CFG_EN_BIT] = en_q;
      end
      ADDR_W'(OFS_CTRL): begin
        mux[CTL_PHY_LSB +: ADR_W] = cmd_q.phy;
        mux[CTL_REG_LSB +: ADR_W] = cmd_q.regad;
        mux[CTL_RD_BIT]           = cmd_q.is_rd;
        mux[CTL_WR_BIT]           = wr_sel_q;
        mux[CTL_RDY_BIT]          = !busy_i;
      end
      ADDR_W'(OFS_WDAT): mux[DAT_W-1:0] = wdat_q;
      ADDR_W'(OFS_RDAT): mux[DAT_W-1:0] = result_i;
      default: mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= DIV_W'(DIV_RST);
      en_q     <= 1'b0;
      cmd_q    <= '0;
      wr_sel_q <= 1'b0;
      wdat_q   <= '0;
      rdata    <= '0;
    end else begin
      if (wr_en && addr == ADDR_W'(OFS_CFG)) begin
        div_q <= wdata[DIV_W-1:0];
        en_q  <= wdata[CFG_EN_BIT];
      end
      if (ctrl_hit && !busy_i) begin
        cmd_q.is_rd <= op_rd;
        cmd_q.phy   <= wdata[CTL_PHY_LSB +: ADR_W];
        cmd_q.regad <= wdata[CTL_REG_LSB +: ADR_W];
        wr_sel_q    <= op_wr;
      end
      if (wr_en && addr == ADDR_W'(OFS_WDAT))
        wdat_q <= wdata[DAT_W-1:0];
      rdata <= mux;
    end
  end

  assign cmd_o  = start_o ? '{is_rd: op_rd, phy: wdata[CTL_PHY_LSB +: ADR_W],
                              regad: wdata[CTL_REG_LSB +: ADR_W]} : cmd_q;
  assign wdat_o = wdat_q;
  assign div_o  = div_q;
  assign en_o   = en_q;
endmodule

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run_i && (cnt_q >= div_i);
  assign rise_o = tick && !mdc_o;
  assign fall_o = tick && mdc_o;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_o <= !mdc_o;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_mgmt_frame.sv
module mdio_mgmt_frame
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DAT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  mdio_cmd_t        cmd_i,
  input  logic [DAT_W-1:0] wdat_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  output logic [DAT_W-1:0] result_o
);
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADR_W + 2 + DAT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int RD_FIRST  = FRAME_LEN - DAT_W;
  localparam int TA_IDX    = RD_FIRST - 2;
  localparam int LAST      = FRAME_LEN - 1;

  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     idx_q, nxt;
  logic [DAT_W-1:0]     cap_q;
  logic                 rd_q;

  assign nxt    = idx_q + CNT_W'(1);
  assign mdio_o = sh_q[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
      rd_q      <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
      cap_q     <= '0;
      result_o  <= '0;
    end else if (start_i) begin
      busy_o    <= 1'b1;
      mdio_oe_o <= 1'b1;
      rd_q      <= cmd_i.is_rd;
      idx_q     <= '0;
      sh_q      <= {{PRE_LEN{1'b1}}, 2'b01, (cmd_i.is_rd ? 2'b10 : 2'b01),
                    cmd_i.phy, cmd_i.regad, 2'b10,
                    (cmd_i.is_rd ? {DAT_W{1'b0}} : wdat_i)};
    end else if (busy_o) begin
      if (rise_i && rd_q && idx_q >= CNT_W'(RD_FIRST))
        cap_q <= {cap_q[DAT_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == CNT_W'(LAST)) begin
          busy_o    <= 1'b0;
          mdio_oe_o <= 1'b0;
          if (rd_q) result_o <= cap_q;
        end else begin
          idx_q     <= nxt;
          sh_q      <= {sh_q[FRAME_LEN-2:0], 1'b0};
          mdio_oe_o <= !(rd_q && nxt >= CNT_W'(TA_IDX));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 6,
  parameter int DIV_RST = 29,
  parameter int PRE_LEN = 32,
  parameter int DAT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic             busy_w, start_w, en_w, rise_w, fall_w;
  mdio_cmd_t        cmd_w;
  logic [DAT_W-1:0] wdat_w, res_w;
  logic [DIV_W-1:0] div_w;

  mdio_mgmt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
                   .DIV_RST(DIV_RST), .DAT_W(DAT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy_i(busy_w), .result_i(res_w),
    .start_o(start_w), .cmd_o(cmd_w), .wdat_o(wdat_w), .div_o(div_w), .en_o(en_w)
  );

  mdio_mgmt_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run_i(busy_w), .div_i(div_w),
    .mdc_o(mdc_o), .rise_o(rise_w), .fall_o(fall_w)
  );

  mdio_mgmt_frame #(.PRE_LEN(PRE_LEN), .DAT_W(DAT_W)) u_frame (
    .clk(clk), .rst(rst), .start_i(start_w), .cmd_i(cmd_w), .wdat_i(wdat_w),
    .rise_i(rise_w), .fall_i(fall_w), .mdio_i(mdio_i), .busy_o(busy_w),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .result_o(res_w)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic start,
  input logic en,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  // R2: clock rests low outside a frame
  p_mdc_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R3: no launch while disabled
  p_no_start_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    (!en && !busy) |=> !busy);

  // R6: output enable low outside a frame
  p_oe_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R6: data output moves only with a falling clock inside a frame
  p_mdio_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  // R9: a frame begins only through an accepted launch
  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind mdio_mgmt_top mdio_mgmt_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy_w), .start(start_w), .en(en_w),
  .mdc(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe_o)
);

// File: tb/mdio_mgmt_top_tb_top.sv
module mdio_mgmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_mgmt_top dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit       rd;
    bit [4:0] phy;
    bit [4:0] ra;
    bit [15:0] data;
    int       div;
  } exp_t;
  exp_t expq[$];

  bit [15:0] phy_resp = '0;
  bit [63:0] cap_o, cap_oe;
  int rise_cnt = 0, rise_total = 0, frames = 0, t_r0 = 0, t_r1 = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit rd, bit wr, bit go, bit [4:0] phy, bit [4:0] ra);
    return (32'(phy) << 24) | (32'(ra) << 16) | (32'(rd) << 15) | (32'(wr) << 14) | (32'(go) << 11);
  endfunction

  task automatic reg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_ready(output logic [31:0] v);
    for (int i = 0; i < 6000; i++) begin
      reg_read(4'h4, v);
      if (v[7]) break;
    end
  endtask

  // monitor / PHY model: decodes each frame and compares with the scoreboard
  initial forever begin
    @(posedge mdc_o);
    cap_o[63-rise_cnt]  = mdio_oe_o ? mdio_o : 1'b0;
    cap_oe[63-rise_cnt] = mdio_oe_o;
    if (rise_cnt == 0) t_r0 = cyc;
    if (rise_cnt == 1) t_r1 = cyc;
    rise_total++;
    rise_cnt++;
    if (rise_cnt == 64) begin
      exp_t e;
      bit [63:0] eo, eoe;
      rise_cnt = 0;
      frames++;
      if (expq.size() == 0) begin
        check(1'b0, "R9", "frame with no expectation", frames, 0);
      end else begin
        e = expq.pop_front();
        eo  = {32'hFFFF_FFFF, 2'b01, (e.rd ? 2'b10 : 2'b01), e.phy, e.ra, 2'b10,
               (e.rd ? 16'h0 : e.data)};
        eoe = e.rd ? ({64{1'b1}} << 18) : {64{1'b1}};
        check(cap_oe == eoe, e.rd ? "R8" : "R7", "output enable pattern", cap_oe, eoe);
        check(cap_o == (eo & eoe), "R6", "frame bits", cap_o, eo & eoe);
        check((t_r1 - t_r0) == 2 * (e.div + 1), "R2", "clock period", t_r1 - t_r0, 2 * (e.div + 1));
      end
    end
  end

  // PHY read response, changed on falling clock
  initial forever begin
    @(negedge mdc_o);
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_resp[15 - (rise_cnt - 48)];
    else mdio_i = 1'b1;
  end

  task automatic xfer(bit rd, bit [4:0] phy, bit [4:0] ra, bit [15:0] data, int div);
    exp_t e;
    logic [31:0] v;
    int n0;
    n0 = frames;
    e.rd = rd; e.phy = phy; e.ra = ra; e.data = data; e.div = div;
    expq.push_back(e);
    if (rd) phy_resp = data;
    else reg_write(4'h8, 32'(data));
    reg_write(4'h4, mk_ctrl(rd, !rd, 1'b1, phy, ra));
    reg_read(4'h4, v);
    check(v[7] == 1'b0, "R5", "ready low during frame", v[7], 0);
    wait_ready(v);
    check(v[7] == 1'b1, "R5", "ready back high", v[7], 1);
    check(v[11] == 1'b0, "R5", "launch bit reads zero", v[11], 0);
    check(v[28:24] == phy && v[20:16] == ra && v[15] == rd && v[14] == !rd,
          "R4", "command readback", v, mk_ctrl(rd, !rd, 1'b0, phy, ra) | 32'h80);
    check(frames == n0 + 1, "R4", "one frame per launch", frames, n0 + 1);
    if (rd) begin
      reg_read(4'hC, v);
      check(v == 32'(data), "R8", "read result", v, data);
    end
  endtask

  initial begin
    logic [31:0] v;
    int n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    reg_read(4'h0, v);
    check(v == 32'd29, "R1", "setup register reset", v, 29);
    reg_read(4'h4, v);
    check(v == 32'h80, "R1", "command register reset", v, 32'h80);
    check(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R1", "pins idle", {mdc_o, mdio_oe_o}, 0);

    // R3: disabled
    reg_write(4'h4, mk_ctrl(1'b0, 1'b1, 1'b1, 5'd1, 5'd1));
    repeat (40) @(negedge clk);
    check(rise_total == 0, "R3", "no clock while disabled", rise_total, 0);
    reg_read(4'h4, v);
    check(v[7] == 1'b1, "R3", "ready high while disabled", v[7], 1);

    reg_write(4'h0, 32'h41);
    xfer(1'b0, 5'd5, 5'h11, 16'hA5C3, 1);
    xfer(1'b1, 5'h1F, 5'h00, 16'h8001, 1);

    // R4: no operation bit, or both
    n0 = rise_total;
    reg_write(4'h4, mk_ctrl(1'b0, 1'b0, 1'b1, 5'd2, 5'd2));
    reg_read(4'h4, v);
    check(v[7] == 1'b1, "R4", "no op bit: not launched", v[7], 1);
    reg_write(4'h4, mk_ctrl(1'b1, 1'b1, 1'b1, 5'd2, 5'd2));
    repeat (30) @(negedge clk);
    check(rise_total == n0, "R4", "invalid ops: no clock", rise_total, n0);

    // R9: command write during a frame
    n0 = frames;
    phy_resp = 16'h1234;
    begin
      exp_t e;
      e.rd = 1; e.phy = 5'd3; e.ra = 5'd4; e.data = 16'h1234; e.div = 1;
      expq.push_back(e);
    end
    reg_write(4'h4, mk_ctrl(1'b1, 1'b0, 1'b1, 5'd3, 5'd4));
    reg_write(4'h4, mk_ctrl(1'b0, 1'b1, 1'b1, 5'd9, 5'd9));
    wait_ready(v);
    check(v[28:24] == 5'd3 && v[15] == 1'b1, "R9", "command unchanged", v[28:24], 3);
    repeat (20) @(negedge clk);
    check(frames == n0 + 1 && expq.size() == 0, "R9", "single frame", frames, n0 + 1);
    reg_read(4'hC, v);
    check(v == 32'h1234, "R8", "read result after busy write", v, 32'h1234);

    reg_write(4'h0, 32'h40);
    xfer(1'b0, 5'd0, 5'h1F, 16'h0001, 0);
    xfer(1'b1, 5'h0A, 5'h15, 16'hFFFE, 0);

    reg_write(4'h0, 32'h40 | 32'd29);
    xfer(1'b0, 5'd1, 5'd2, 16'h5A5A, 29);
    repeat (10) @(negedge clk);
    check(mdc_o == 1'b0, "R2", "clock low after frame", mdc_o, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule